// File: doc/BRIEF.md
# Byte-Stream Frame Check Sequence Generator and Checker

This block sits in the byte-wide datapath of a network interface controller and handles the 32-bit frame check sequence of Ethernet frames in both directions. On the transmit side it forwards each frame byte and computes the CRC as the bytes go by. Once the last byte has been accepted, it inserts the four FCS bytes into the outgoing stream. While it does so, it holds off the upstream source for four cycles.

On the receive side the block forwards every byte unchanged, the FCS bytes included. It runs the same CRC over the whole frame. When the frame ends, it gives a one-cycle verdict that says whether the CRC register holds the fixed residue that an intact frame leaves behind.

The datapath is fully transparent in both directions. The length/type field is never decoded, no padding is added or removed, and frames of any length are processed. Each direction marks its bytes with a valid strobe, a start-of-frame flag and an end-of-frame flag.

Top module: `eth_fcs_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, tx_out_valid, rx_out_valid, rx_good and rx_bad are 0 and tx_in_ready is 1.
- R2: The CRC uses the polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. The register presets to all ones at every byte flagged start-of-frame. Bits are taken least significant bit first within each byte. For the nine ASCII bytes "123456789", the appended FCS bytes are 8'h26, 8'h39, 8'hF4, 8'hCB in that order.
- R3: Each transmit byte accepted (tx_in_valid and tx_in_ready both 1) appears on tx_out_data with tx_out_valid one cycle later, unchanged. tx_out_sof copies the start flag, and tx_out_eof is 0 for these bytes.
- R4: After the accepted byte flagged end-of-frame, the next four cycles carry the bit-inverted CRC register on tx_out_data, least significant byte first, with tx_out_valid 1. tx_out_eof is 1 only on the fourth of these bytes.
- R5: tx_in_ready is 0 during exactly the four cycles in which FCS bytes are emitted, and 1 at all other times.
- R6: Each receive byte with rx_valid 1 appears one cycle later on rx_out_data with rx_out_valid 1, together with its own start and end flags, FCS bytes included.
- R7: One cycle after a receive byte flagged end-of-frame, exactly one of rx_good or rx_bad pulses for one cycle. rx_good pulses when the LSB-first CRC register, including that byte, equals 32'hDEBB20E3. That is the bit-reversed form of 32'hC704DD7B. Otherwise rx_bad pulses.
- R8: A receive byte flagged start-of-frame restarts the CRC from the preset, even in the cycle right after an end-of-frame byte. A byte flagged both start and end forms a one-byte frame.
- R9: Frame content and length are never interpreted. Short frames (5 payload bytes), frames longer than 1500 data bytes, and any length/type value all pass through unchanged and are judged by the CRC alone.
- R10: Cycles with the valid strobe low, in the middle of a frame, leave the CRC unchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_sof | input | 1 | Transmit input byte is first of frame |
| tx_in_eof | input | 1 | Transmit input byte is last of frame |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_ready | output | 1 | Transmit input may be accepted this cycle |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_sof | output | 1 | Transmit output byte is first of frame |
| tx_out_eof | output | 1 | Transmit output byte is last FCS byte |
| tx_out_data | output | 8 | Transmit output byte |
| rx_valid | input | 1 | Receive input byte valid |
| rx_sof | input | 1 | Receive input byte is first of frame |
| rx_eof | input | 1 | Receive input byte is last of frame (last FCS byte) |
| rx_data | input | 8 | Receive input byte |
| rx_out_valid | output | 1 | Receive forwarded byte valid |
| rx_out_sof | output | 1 | Receive forwarded start flag |
| rx_out_eof | output | 1 | Receive forwarded end flag |
| rx_out_data | output | 8 | Receive forwarded byte |
| rx_good | output | 1 | One-cycle pulse: frame CRC correct |
| rx_bad | output | 1 | One-cycle pulse: frame CRC wrong |

## Verification
On the receive side, the verdict for one frame and the start of the next frame can fall in the same cycle. The pulse for frame A is registered in the cycle in which frame B's first byte arrives and the CRC register is preset again. The bench provokes this by sending a corrupted frame followed, with no idle cycle, by a good frame and then a one-byte frame. It requires the verdicts bad, good and the computed one, in that order. It also requires the first verdict to be seen in exactly the cycle in which the second frame's first byte is driven.

// File: rtl/eth_fcs_pkg.sv
package eth_fcs_pkg;

    localparam int BYTE_W    = 8;
    localparam int CRC_W     = 32;
    localparam int FCS_BYTES = CRC_W / BYTE_W;
    localparam int IDX_W     = $clog2(FCS_BYTES);

    // Register is kept in LSB-first (shift-right) form.
    localparam logic [CRC_W-1:0] CRC_PRESET   = '1;
    localparam logic [CRC_W-1:0] POLY_LSBF    = 32'hEDB88320;
    localparam logic [CRC_W-1:0] RESIDUE_LSBF = 32'hDEBB20E3;

    typedef struct packed {
        logic              sof;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef enum logic [0:0] {
        TX_PASS   = 1'b0,
        TX_APPEND = 1'b1
    } tx_state_e;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  cur,
        input logic [BYTE_W-1:0] din
    );
        logic [CRC_W-1:0] r;
        r = cur ^ {{(CRC_W-BYTE_W){1'b0}}, din};
        for (int b = 0; b < BYTE_W; b++) begin
            r = r[0] ? ((r >> 1) ^ POLY_LSBF) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_crc_reg.sv
module fcs_crc_reg
    import eth_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              restart,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q,
    output logic [CRC_W-1:0]  crc_next
);

    logic [CRC_W-1:0] base;

    always_comb begin
        base     = restart ? CRC_PRESET : crc_q;
        crc_next = crc_step_byte(base, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_PRESET;
        end else if (step) begin
            crc_q <= crc_next;
        end
    end

endmodule

// File: rtl/fcs_tx_append.sv
module fcs_tx_append
    import eth_fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  beat_t in_beat,
    output logic  in_ready,
    output logic  out_valid,
    output beat_t out_beat
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

    tx_state_e        state;
    logic [IDX_W-1:0] idx;
    logic             take;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] crc_inv;
    logic [BYTE_W-1:0] fcs_byte;

    assign in_ready = (state == TX_PASS);
    assign take     = in_valid && in_ready;
    assign crc_inv  = ~crc_q;
    assign fcs_byte = crc_inv[{idx, 3'b000} +: BYTE_W];

    fcs_crc_reg u_crc (
        .clk      (clk),
        .rst      (rst),
        .step     (take),
        .restart  (in_beat.sof),
        .din      (in_beat.data),
        .crc_q    (crc_q),
        .crc_next (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_PASS;
            idx       <= '0;
            out_valid <= 1'b0;
            out_beat  <= '0;
        end else begin
            case (state)
                TX_PASS: begin
                    out_valid    <= take;
                    out_beat.eof <= 1'b0;
                    out_beat.sof <= take && in_beat.sof;
                    if (take) begin
                        out_beat.data <= in_beat.data;
                        if (in_beat.eof) begin
                            state <= TX_APPEND;
                            idx   <= '0;
                        end
                    end
                end
                TX_APPEND: begin
                    out_valid     <= 1'b1;
                    out_beat.sof  <= 1'b0;
                    out_beat.data <= fcs_byte;
                    out_beat.eof  <= (idx == LAST_IDX);
                    idx           <= idx + 1'b1;
                    if (idx == LAST_IDX) begin
                        state <= TX_PASS;
                    end
                end
                default: state <= TX_PASS;
            endcase
        end
    end

endmodule

// File: rtl/fcs_rx_check.sv
module fcs_rx_check
    import eth_fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  beat_t in_beat,
    output logic  out_valid,
    output beat_t out_beat,
    output logic  good,
    output logic  bad
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             ends;
    logic             match;

    assign ends  = in_valid && in_beat.eof;
    assign match = (crc_next == RESIDUE_LSBF);

    fcs_crc_reg u_crc (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .restart  (in_beat.sof),
        .din      (in_beat.data),
        .crc_q    (crc_q),
        .crc_next (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_beat  <= '0;
            good      <= 1'b0;
            bad       <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            out_beat.sof <= in_valid && in_beat.sof;
            out_beat.eof <= ends;
            if (in_valid) begin
                out_beat.data <= in_beat.data;
            end
            good <= ends && match;
            bad  <= ends && !match;
        end
    end

endmodule

// File: rtl/eth_fcs_unit.sv
module eth_fcs_unit
    import eth_fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_in_valid,
    input  logic              tx_in_sof,
    input  logic              tx_in_eof,
    input  logic [BYTE_W-1:0] tx_in_data,
    output logic              tx_in_ready,
    output logic              tx_out_valid,
    output logic              tx_out_sof,
    output logic              tx_out_eof,
    output logic [BYTE_W-1:0] tx_out_data,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_out_valid,
    output logic              rx_out_sof,
    output logic              rx_out_eof,
    output logic [BYTE_W-1:0] rx_out_data,
    output logic              rx_good,
    output logic              rx_bad
);

    beat_t tx_in_b;
    beat_t tx_out_b;
    beat_t rx_in_b;
    beat_t rx_out_b;

    assign tx_in_b = '{sof: tx_in_sof, eof: tx_in_eof, data: tx_in_data};
    assign rx_in_b = '{sof: rx_sof, eof: rx_eof, data: rx_data};

    fcs_tx_append u_tx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (tx_in_valid),
        .in_beat   (tx_in_b),
        .in_ready  (tx_in_ready),
        .out_valid (tx_out_valid),
        .out_beat  (tx_out_b)
    );

    fcs_rx_check u_rx (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (rx_valid),
        .in_beat   (rx_in_b),
        .out_valid (rx_out_valid),
        .out_beat  (rx_out_b),
        .good      (rx_good),
        .bad       (rx_bad)
    );

    assign tx_out_sof  = tx_out_b.sof;
    assign tx_out_eof  = tx_out_b.eof;
    assign tx_out_data = tx_out_b.data;
    assign rx_out_sof  = rx_out_b.sof;
    assign rx_out_eof  = rx_out_b.eof;
    assign rx_out_data = rx_out_b.data;

endmodule

// File: rtl/eth_fcs_unit_chk.sv
module eth_fcs_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_in_valid,
    input logic       tx_in_sof,
    input logic       tx_in_eof,
    input logic [7:0] tx_in_data,
    input logic       tx_in_ready,
    input logic       tx_out_valid,
    input logic       tx_out_sof,
    input logic       tx_out_eof,
    input logic [7:0] tx_out_data,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic       rx_eof,
    input logic [7:0] rx_data,
    input logic       rx_out_valid,
    input logic       rx_out_sof,
    input logic       rx_out_eof,
    input logic [7:0] rx_out_data,
    input logic       rx_good,
    input logic       rx_bad
);

    p_tx_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && tx_in_ready) |=>
            (tx_out_valid && tx_out_data == $past(tx_in_data) && !tx_out_eof));

    p_tx_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && tx_in_ready && tx_in_eof) |=> (!tx_in_ready && !tx_out_eof));

    p_tx_eof_valid_r4: assert property (@(posedge clk) disable iff (rst)
        tx_out_eof |-> (tx_out_valid && !tx_out_sof));

    p_tx_ready_back_r5: assert property (@(posedge clk) disable iff (rst)
        tx_out_eof |-> tx_in_ready);

    p_rx_pass_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (rx_out_valid && rx_out_data == $past(rx_data)
                      && rx_out_sof == $past(rx_sof) && rx_out_eof == $past(rx_eof)));

    p_verdict_one_r7: assert property (@(posedge clk) disable iff (rst)
        !(rx_good && rx_bad));

    p_verdict_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_eof) |=> (rx_good || rx_bad));

    p_verdict_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_good || rx_bad) |-> (rx_out_valid && rx_out_eof));

endmodule

bind eth_fcs_unit eth_fcs_unit_chk u_chk (.*);

// File: tb/tb_eth_fcs_unit.sv
module tb_eth_fcs_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic       tx_in_valid, tx_in_sof, tx_in_eof;
    logic [7:0] tx_in_data;
    logic       tx_in_ready, tx_out_valid, tx_out_sof, tx_out_eof;
    logic [7:0] tx_out_data;
    logic       rx_valid, rx_sof, rx_eof;
    logic [7:0] rx_data;
    logic       rx_out_valid, rx_out_sof, rx_out_eof;
    logic [7:0] rx_out_data;
    logic       rx_good, rx_bad;

    always #4 clk = ~clk;

    eth_fcs_unit dut (.*);

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rdy_low = 0;

    logic [7:0] frm[$];
    logic [7:0] txd[$];
    logic       txs[$];
    logic       txe[$];
    logic [7:0] rxd[$];
    int         vq[$];
    int         vc[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_out_valid) begin
                txd.push_back(tx_out_data);
                txs.push_back(tx_out_sof);
                txe.push_back(tx_out_eof);
            end
            if (!tx_in_ready) rdy_low++;
            if (rx_out_valid) rxd.push_back(rx_out_data);
            if (rx_good || rx_bad) begin
                vq.push_back((rx_good && rx_bad) ? 2 : (rx_good ? 1 : 0));
                vc.push_back(cyc);
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    // MSB-first register form, bits fed LSB-first
    function automatic logic [31:0] crc_msb();
        logic [31:0] c;
        logic fb;
        c = '1;
        foreach (frm[i]) begin
            for (int b = 0; b < 8; b++) begin
                fb = c[31] ^ frm[i][b];
                c = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] fcs_word();
        return ~rev32(crc_msb());
    endfunction

    task automatic add_fcs();
        logic [31:0] v;
        v = fcs_word();
        for (int k = 0; k < 4; k++) frm.push_back(v[8*k +: 8]);
    endtask

    task automatic clear_caps();
        txd.delete(); txs.delete(); txe.delete();
        rxd.delete(); vq.delete(); vc.delete();
        rdy_low = 0;
    endtask

    task automatic drive_tx(input int gap);
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            tx_in_valid = 1'b0;
            while (!tx_in_ready) @(negedge clk);
            tx_in_valid = 1'b1;
            tx_in_sof   = (i == 0);
            tx_in_eof   = (i == frm.size() - 1);
            tx_in_data  = frm[i];
            if (gap > 0 && (i % gap) == gap - 1 && i != frm.size() - 1) begin
                @(negedge clk);
                tx_in_valid = 1'b0;
                tx_in_data  = 8'hA5;
            end
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_sof   = 1'b0;
        tx_in_eof   = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic drive_rx(input int gap, input bit idle_after);
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == frm.size() - 1);
            rx_data  = frm[i];
            if (gap > 0 && (i % gap) == gap - 1 && i != frm.size() - 1) begin
                @(negedge clk);
                rx_valid = 1'b0;
                rx_data  = 8'h3C;
            end
        end
        if (idle_after) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_sof   = 1'b0;
            rx_eof   = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic check_tx(input string req, input int plen);
        logic [31:0] v;
        v = fcs_word();
        chk(req, "tx count", txd.size(), plen + 4);
        if (txd.size() == plen + 4) begin
            for (int i = 0; i < plen; i++) begin
                chk("R3", "tx data", txd[i], frm[i]);
                chk("R3", "tx sof", txs[i], i == 0);
                chk("R4", "tx eof early", txe[i], 1'b0);
            end
            for (int k = 0; k < 4; k++) begin
                chk("R4", "fcs byte", txd[plen+k], v[8*k +: 8]);
                chk("R4", "fcs eof", txe[plen+k], k == 3);
            end
        end
        chk("R5", "ready low cycles", rdy_low, 4);
    endtask

    task automatic check_rx(input string req, input int exp_v);
        chk(req, "rx count", rxd.size(), frm.size());
        if (rxd.size() == frm.size())
            foreach (frm[i]) chk("R6", "rx data", rxd[i], frm[i]);
        chk("R7", "verdict count", vq.size(), 1);
        if (vq.size() == 1) chk(req, "verdict", vq[0], exp_v);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tx_in_valid = 0; tx_in_sof = 0; tx_in_eof = 0; tx_in_data = 0;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
        repeat (3) @(negedge clk);
        chk("R1", "reset tx_out_valid", tx_out_valid, 0);
        chk("R1", "reset tx_in_ready", tx_in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "post rx_out_valid", rx_out_valid, 0);
        chk("R1", "post verdicts", {rx_good, rx_bad}, 2'b00);
    endtask

    task automatic t_tx_known();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 9; i++) frm.push_back(8'h31 + 8'(i));
        drive_tx(0);
        check_tx("R4", 9);
        if (txd.size() == 13)
            chk("R2", "known fcs", {txd[9], txd[10], txd[11], txd[12]}, 32'h2639F4CB);
    endtask

    task automatic t_tx_gaps();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 60; i++) frm.push_back(8'(i * 7 + 3));
        drive_tx(3);
        check_tx("R10", 60);
    endtask

    task automatic t_rx_short();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 12; i++) frm.push_back(8'(8'hF0 ^ i));
        frm.push_back(8'h00); frm.push_back(8'h05);
        for (int i = 0; i < 5; i++) frm.push_back(8'(i + 1));
        add_fcs();
        drive_rx(0, 1);
        check_rx("R9", 1);
    endtask

    task automatic t_rx_corrupt();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 64; i++) frm.push_back(8'(i * 13));
        add_fcs();
        frm[20] = frm[20] ^ 8'h10;
        drive_rx(0, 1);
        check_rx("R7", 0);
    endtask

    task automatic t_rx_long();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 12; i++) frm.push_back(8'(i));
        frm.push_back(8'h00); frm.push_back(8'h10);
        for (int i = 0; i < 1600; i++) frm.push_back((i < 800) ? 8'(i) : 8'h00);
        add_fcs();
        drive_rx(0, 1);
        check_rx("R9", 1);
    endtask

    task automatic t_rx_gaps();
        clear_caps();
        frm.delete();
        for (int i = 0; i < 40; i++) frm.push_back(8'(8'h55 + i * 3));
        add_fcs();
        drive_rx(2, 1);
        check_rx("R10", 1);
    endtask

    task automatic t_rx_back_to_back();
        int b0_cyc;
        int exp_c;
        clear_caps();
        frm.delete();
        for (int i = 0; i < 20; i++) frm.push_back(8'(i + 9));
        add_fcs();
        frm[3] = ~frm[3];
        drive_rx(0, 0);
        frm.delete();
        for (int i = 0; i < 20; i++) frm.push_back(8'(i * 5));
        add_fcs();
        @(negedge clk);
        b0_cyc = cyc;
        rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b0; rx_data = frm[0];
        frm.delete(0);
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            rx_sof = 1'b0;
            rx_eof = (i == frm.size() - 1);
            rx_data = frm[i];
        end
        frm.delete();
        frm.push_back(8'h9E);
        exp_c = (crc_msb() == 32'hC704DD7B) ? 1 : 0;
        @(negedge clk);
        rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h9E;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8", "verdict count", vq.size(), 3);
        if (vq.size() == 3) begin
            chk("R8", "first frame bad", vq[0], 0);
            chk("R8", "second frame good", vq[1], 1);
            chk("R8", "one-byte frame", vq[2], exp_c);
            chk("R8", "verdict with next sof", vc[0], b0_cyc);
        end
    endtask

    initial begin
        t_reset();
        t_tx_known();
        t_tx_gaps();
        t_rx_short();
        t_rx_corrupt();
        t_rx_long();
        t_rx_gaps();
        t_rx_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule